// File: doc/BRIEF.md
# Serial Three-Wire EEPROM Slave Model

This block is a synthesizable stand-in for a 2 Kbit serial EEPROM that speaks the common three-wire select/clock/data protocol. A host frames each command while chip select is high: a start bit, a two-bit opcode, an address field and, for the program commands, a data word. All fields are sampled on rising serial-clock edges, which the block detects by oversampling `sk` with its own system clock. The storage is a register array, so contents last only as long as the block stays out of reset.

Reading streams words out of the array, one bit per serial clock, and moves on to the next address by itself. Programming commands run through an internal timer that stands in for the cell programming time. While the timer runs, the host can reselect the block and read its progress on the data output. A write lock, set at reset and changed only by dedicated commands, guards every command that alters the array. One input pin chooses between 128 words of 16 bits and 256 words of 8 bits.

Top module: `mwe_eeprom_model`

## Requirements
- R1: After reset, the data output is not driven (`do_oe`=0), the write lock is set, and every stored bit reads as 1.
- R2: `do_oe` is 0 one system clock after `cs` is low, and is 0 while the block is selected but neither streaming read data nor showing status.
- R3: A frame is start bit 1 followed by the opcode (10 = read, 01 = write, 11 = erase, 00 = extended). For a read, the system clock edge that registers the last address bit drives a 0 on `do_o` with `do_oe`=1. Each later serial clock rise then presents the next data bit, MSB first.
- R4: After the LSB of a word, the next serial clock rise presents the MSB of the following address, with no extra 0 bit. The address wraps from the last word to word 0.
- R5: With the lock cleared, write (opcode 01, address, then a data word MSB first) stores the word once chip select falls and the programming time has run.
- R6: With the lock set, write, erase, erase-all and write-all change nothing and start no busy period. Extended command 11 clears the lock and extended command 00 sets it; the extended code is the top two bits of the address field.
- R7: Erase (opcode 11) sets the addressed word to all ones.
- R8: Erase-all (extended code 10) sets every word to all ones.
- R9: Write-all (extended code 01, then one data word) stores that word in every location.
- R10: After chip select falls on an accepted program command, reselecting drives `do_o`=0 while busy. `do_o` changes to 1 once `PROG_CYCLES` system clocks have passed. The status stays shown until a start bit is received or chip select falls while ready.
- R11: With `org`=0 the address field is 9 bits and its MSB is ignored. Byte address b maps to 16-bit word b>>1: the upper byte when b is even, the lower byte when b is odd. Data fields are 8 bits. With `org`=1 the address field is 8 bits (top bit ignored for word selection) and data fields are 16 bits.
- R12: Every serial clock while a program cycle runs is ignored, so a whole command sent during busy has no effect.
- R13: A frame cut short by chip select falling before its last bit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins and times programming |
| rst_n | input | 1 | Active-low asynchronous reset (power-up lockout) |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data into the block |
| org | input | 1 | Word organization: 1 = 128x16, 0 = 256x8 |
| do_o | output | 1 | Serial data / status value |
| do_oe | output | 1 | Output enable for `do_o`; 0 means high impedance |

## Verification
Every result on `do_o` is registered on the system clock edge that first sees `sk` high. The bench therefore holds each serial clock phase for four system clocks and samples at the end of the high phase, which is well after that edge and before the next rise. The extra 0 bit is sampled after the pulse carrying the last address bit, and each data bit after the pulse that follows. Status appears one system clock after reselect, and busy lasts exactly `PROG_CYCLES` system clocks starting one clock after chip select falls. The bench checks busy a few clocks after reselect and ready only after `PROG_CYCLES` plus a margin, so neither check sits near a boundary.

// File: rtl/mwe_pkg.sv
package mwe_pkg;

   typedef enum logic [1:0] {
      OPC_EXT   = 2'b00,
      OPC_WRITE = 2'b01,
      OPC_READ  = 2'b10,
      OPC_ERASE = 2'b11
   } opc_e;

   typedef enum logic [1:0] {
      EXT_LOCK   = 2'b00,
      EXT_FILL   = 2'b01,
      EXT_CLRALL = 2'b10,
      EXT_UNLOCK = 2'b11
   } ext_e;

   typedef enum logic [2:0] {
      PG_NONE,
      PG_WRITE,
      PG_ERASE,
      PG_CLRALL,
      PG_FILL
   } pg_op_e;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_OPC,
      RX_ADDR,
      RX_DATA,
      RX_READ,
      RX_HOLD
   } rx_st_e;

endpackage

// File: rtl/mwe_store.sv
module mwe_store
   import mwe_pkg::*;
#(
   parameter int WORD_W         = 16,
   parameter int DEPTH          = 128,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  pg_op_e                    wr_op,
   input  logic                      wr_org,
   input  logic [$clog2(DEPTH):0]    wr_addr,
   input  logic [WORD_W-1:0]         wr_data,
   input  logic                      rd_org,
   input  logic [$clog2(DEPTH):0]    rd_addr,
   output logic [WORD_W-1:0]         rd_data
);
   localparam int IW     = $clog2(DEPTH);
   localparam int BYTE_W = WORD_W / 2;

   logic [DEPTH-1:0][WORD_W-1:0] words;
   logic [WORD_W-1:0]            fill;
   logic                         all_hit;

   always_comb begin
      fill    = (wr_op == PG_ERASE || wr_op == PG_CLRALL) ? '1 : wr_data;
      all_hit = (wr_op == PG_CLRALL || wr_op == PG_FILL);
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      logic              hit;
      logic [WORD_W-1:0] nxt;
      logic [WORD_W-1:0] word_q;

      always_comb begin
         nxt = word_q;
         if (wr_org) begin
            hit = all_hit || (wr_addr[IW-1:0] == IW'(i));
            nxt = fill;
         end else begin
            hit = all_hit || (wr_addr[IW:1] == IW'(i));
            if (all_hit) begin
               nxt = {fill[BYTE_W-1:0], fill[BYTE_W-1:0]};
            end else if (!wr_addr[0]) begin
               nxt = {fill[BYTE_W-1:0], word_q[BYTE_W-1:0]};
            end else begin
               nxt = {word_q[WORD_W-1:BYTE_W], fill[BYTE_W-1:0]};
            end
         end
      end

      if (CLEAR_ON_RESET) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               word_q <= '1;
            end else if (we && hit) begin
               word_q <= nxt;
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (we && hit) begin
               word_q <= nxt;
            end
         end
      end

      assign words[i] = word_q;
   end

   logic [WORD_W-1:0] rd_word;

   always_comb begin
      rd_word = rd_org ? words[rd_addr[IW-1:0]] : words[rd_addr[IW:1]];
      if (rd_org) begin
         rd_data = rd_word;
      end else if (rd_addr[0]) begin
         rd_data = {{BYTE_W{1'b0}}, rd_word[BYTE_W-1:0]};
      end else begin
         rd_data = {{BYTE_W{1'b0}}, rd_word[WORD_W-1:BYTE_W]};
      end
   end

   // R9: a fill or clear-all only ever happens with a known all-word opcode
   p_fill_op_known_r9: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (wr_op != PG_NONE));

endmodule

// File: rtl/mwe_timer.sv
module mwe_timer #(
   parameter int PROG_CYCLES = 400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   output logic busy,
   output logic done
);
   localparam int CW = $clog2(PROG_CYCLES);
   localparam logic [CW-1:0] LAST = CW'(PROG_CYCLES - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (launch && !busy) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (busy) begin
         if (cnt == LAST) begin
            busy <= 1'b0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign done = busy && (cnt == LAST);

   // R10: the count never runs past the programming window
   p_cnt_in_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt <= LAST));

   // R10: busy ends on the cycle after the commit
   p_done_ends_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   // R12: no new start is requested while a cycle runs
   p_no_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !launch);

endmodule

// File: rtl/mwe_rx.sv
module mwe_rx
   import mwe_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int DEPTH  = 128
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cs,
   input  logic                      sk_rise,
   input  logic                      di,
   input  logic                      org,
   input  logic                      busy,
   input  logic [WORD_W-1:0]         rd_data,
   output logic [$clog2(DEPTH):0]    rd_addr,
   output logic                      rd_bit,
   output logic                      rd_oe,
   output logic                      unlock,
   output logic                      lock,
   output logic                      req_valid,
   output pg_op_e                    req_op,
   output logic [$clog2(DEPTH):0]    req_addr,
   output logic [WORD_W-1:0]         req_data,
   output logic                      start_seen
);
   localparam int IW     = $clog2(DEPTH);
   localparam int BA_W   = IW + 1;
   localparam int AL16   = IW + 1;
   localparam int AL8    = IW + 2;
   localparam int BYTE_W = WORD_W / 2;
   localparam int CW     = $clog2(AL8 + WORD_W);
   localparam int BW     = $clog2(WORD_W);

   rx_st_e            st;
   opc_e              opc;
   logic [CW-1:0]     cnt;
   logic [AL8-1:0]    ash;
   logic [WORD_W-1:0] dsh;
   logic [BW-1:0]     bidx;

   logic [CW-1:0]     alen_m1;
   logic [CW-1:0]     dlen_m1;
   logic [BW-1:0]     bidx_top;
   logic [AL8-1:0]    ash_n;
   logic [WORD_W-1:0] dsh_n;
   logic [BA_W-1:0]   waddr;
   logic [1:0]        top2;
   logic [BA_W-1:0]   rd_next;

   always_comb begin
      alen_m1  = org ? CW'(AL16 - 1) : CW'(AL8 - 1);
      dlen_m1  = org ? CW'(WORD_W - 1) : CW'(BYTE_W - 1);
      bidx_top = org ? BW'(WORD_W - 1) : BW'(BYTE_W - 1);
      ash_n    = {ash[AL8-2:0], di};
      dsh_n    = {dsh[WORD_W-2:0], di};
      waddr    = org ? {1'b0, ash_n[IW-1:0]} : ash_n[IW:0];
      top2     = org ? ash_n[AL16-1 -: 2] : ash_n[AL8-1 -: 2];
      rd_next  = rd_addr + 1'b1;
      if (org) begin
         rd_next[IW] = 1'b0;
      end
   end

   assign start_seen = cs && sk_rise && di && !busy && (st == RX_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= RX_IDLE;
         opc       <= OPC_EXT;
         cnt       <= '0;
         ash       <= '0;
         dsh       <= '0;
         bidx      <= '0;
         rd_addr   <= '0;
         rd_bit    <= 1'b0;
         rd_oe     <= 1'b0;
         unlock    <= 1'b0;
         lock      <= 1'b0;
         req_valid <= 1'b0;
         req_op    <= PG_NONE;
         req_addr  <= '0;
         req_data  <= '0;
      end else begin
         unlock <= 1'b0;
         lock   <= 1'b0;
         if (!cs) begin
            st        <= RX_IDLE;
            rd_oe     <= 1'b0;
            req_valid <= 1'b0;
         end else if (sk_rise) begin
            case (st)
               RX_IDLE: begin
                  if (di && !busy) begin
                     st  <= RX_OPC;
                     cnt <= '0;
                  end
               end
               RX_OPC: begin
                  opc <= opc_e'({opc[0], di});
                  if (cnt == CW'(1)) begin
                     st  <= RX_ADDR;
                     cnt <= '0;
                     ash <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_ADDR: begin
                  ash <= ash_n;
                  if (cnt == alen_m1) begin
                     cnt <= '0;
                     dsh <= '0;
                     case (opc)
                        OPC_READ: begin
                           rd_addr <= waddr;
                           bidx    <= bidx_top;
                           rd_bit  <= 1'b0;
                           rd_oe   <= 1'b1;
                           st      <= RX_READ;
                        end
                        OPC_WRITE: begin
                           req_op   <= PG_WRITE;
                           req_addr <= waddr;
                           st       <= RX_DATA;
                        end
                        OPC_ERASE: begin
                           req_op    <= PG_ERASE;
                           req_addr  <= waddr;
                           req_valid <= 1'b1;
                           st        <= RX_HOLD;
                        end
                        default: begin
                           case (ext_e'(top2))
                              EXT_UNLOCK: begin
                                 unlock <= 1'b1;
                                 st     <= RX_HOLD;
                              end
                              EXT_LOCK: begin
                                 lock <= 1'b1;
                                 st   <= RX_HOLD;
                              end
                              EXT_CLRALL: begin
                                 req_op    <= PG_CLRALL;
                                 req_valid <= 1'b1;
                                 st        <= RX_HOLD;
                              end
                              default: begin
                                 req_op <= PG_FILL;
                                 st     <= RX_DATA;
                              end
                           endcase
                        end
                     endcase
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_DATA: begin
                  dsh <= dsh_n;
                  if (cnt == dlen_m1) begin
                     req_data  <= dsh_n;
                     req_valid <= 1'b1;
                     st        <= RX_HOLD;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_READ: begin
                  rd_bit <= rd_data[bidx];
                  if (bidx == '0) begin
                     bidx    <= bidx_top;
                     rd_addr <= rd_next;
                  end else begin
                     bidx <= bidx - 1'b1;
                  end
               end
               default: begin
               end
            endcase
         end
      end
   end

   // R3: while streaming a read the output stays enabled
   p_read_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RX_READ) |-> rd_oe);

   // R2: an idle receiver never enables read data
   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RX_IDLE) |-> !rd_oe);

   // R13: a request is only pending inside a completed frame
   p_req_in_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (st == RX_HOLD));

endmodule

// File: rtl/mwe_eeprom_model.sv
module mwe_eeprom_model
   import mwe_pkg::*;
#(
   parameter int WORD_W         = 16,
   parameter int DEPTH          = 128,
   parameter int PROG_CYCLES    = 400,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs,
   input  logic sk,
   input  logic di,
   input  logic org,
   output logic do_o,
   output logic do_oe
);
   localparam int BA_W = $clog2(DEPTH) + 1;

   if (WORD_W < 2 || (WORD_W % 2) != 0) begin : g_bad_width
      $error("WORD_W must be even and at least 2");
   end
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if (PROG_CYCLES < 2) begin : g_bad_prog
      $error("PROG_CYCLES must be at least 2");
   end

   logic sk_q;
   logic cs_q;
   logic sk_rise;
   logic cs_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sk_q <= 1'b0;
         cs_q <= 1'b0;
      end else begin
         sk_q <= sk;
         cs_q <= cs;
      end
   end

   assign sk_rise = sk && !sk_q;
   assign cs_fall = cs_q && !cs;

   logic [WORD_W-1:0] rd_data;
   logic [BA_W-1:0]   rd_addr;
   logic              rd_bit;
   logic              rd_oe;
   logic              unlock;
   logic              lock;
   logic              req_valid;
   pg_op_e            req_op;
   logic [BA_W-1:0]   req_addr;
   logic [WORD_W-1:0] req_data;
   logic              start_seen;
   logic              busy;
   logic              done;

   mwe_rx #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs         (cs),
      .sk_rise    (sk_rise),
      .di         (di),
      .org        (org),
      .busy       (busy),
      .rd_data    (rd_data),
      .rd_addr    (rd_addr),
      .rd_bit     (rd_bit),
      .rd_oe      (rd_oe),
      .unlock     (unlock),
      .lock       (lock),
      .req_valid  (req_valid),
      .req_op     (req_op),
      .req_addr   (req_addr),
      .req_data   (req_data),
      .start_seen (start_seen)
   );

   logic              wen_q;
   logic              status_q;
   logic              launch;
   pg_op_e            pg_op;
   logic [BA_W-1:0]   pg_addr;
   logic [WORD_W-1:0] pg_data;
   logic              pg_org;

   assign launch = cs_fall && req_valid && wen_q && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wen_q    <= 1'b0;
         status_q <= 1'b0;
         pg_op    <= PG_NONE;
         pg_addr  <= '0;
         pg_data  <= '0;
         pg_org   <= 1'b1;
      end else begin
         if (unlock) begin
            wen_q <= 1'b1;
         end else if (lock) begin
            wen_q <= 1'b0;
         end
         if (launch) begin
            status_q <= 1'b1;
            pg_op    <= req_op;
            pg_addr  <= req_addr;
            pg_data  <= req_data;
            pg_org   <= org;
         end else if (!busy && (start_seen || cs_fall)) begin
            status_q <= 1'b0;
         end
      end
   end

   mwe_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .launch (launch),
      .busy   (busy),
      .done   (done)
   );

   mwe_store #(
      .WORD_W         (WORD_W),
      .DEPTH          (DEPTH),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (done),
      .wr_op   (pg_op),
      .wr_org  (pg_org),
      .wr_addr (pg_addr),
      .wr_data (pg_data),
      .rd_org  (org),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   assign do_oe = cs_q && (rd_oe || status_q);
   assign do_o  = rd_oe ? rd_bit : (status_q ? !busy : 1'b0);

   // R2: deselect releases the output by the next clock
   p_desel_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |=> !do_oe);

   // R6: a program cycle only starts while the lock is cleared
   p_locked_no_prog_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wen_q));

   // R12: no read stream can run while programming
   p_busy_no_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !rd_oe);

endmodule

// File: tb/tb_mwe_eeprom_model.sv
module tb_mwe_eeprom_model;
   localparam int PROG = 400;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0;
   logic sk = 1'b0;
   logic di = 1'b0;
   logic org = 1'b1;
   logic do_o;
   logic do_oe;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   bit    exp_oe[$];
   bit    exp_do[$];
   string exp_tag[$];
   event  smp;

   always #10 clk = ~clk;

   mwe_eeprom_model #(.PROG_CYCLES(PROG)) dut (
      .clk   (clk),
      .rst_n (rst_n),
      .cs    (cs),
      .sk    (sk),
      .di    (di),
      .org   (org),
      .do_o  (do_o),
      .do_oe (do_oe)
   );

   task automatic drain();
      while (exp_oe.size() > 0) begin
         bit eo = exp_oe.pop_front();
         bit ed = exp_do.pop_front();
         string tg = exp_tag.pop_front();
         checks++;
         if (do_oe !== eo || (eo && do_o !== ed)) begin
            errors++;
            $display("FAIL %s: got oe=%0b do=%0b expected oe=%0b do=%0b",
                     tg, do_oe, do_o, eo, ed);
         end
      end
   endtask

   initial begin
      forever begin
         @(smp);
         drain();
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(bit eo, bit ed, string tag);
      exp_oe.push_back(eo);
      exp_do.push_back(ed);
      exp_tag.push_back(tag);
      -> smp;
      tick(1);
   endtask

   task automatic pulse(bit b);
      di = b;
      sk = 1'b0;
      tick(4);
      sk = 1'b1;
      tick(4);
   endtask

   task automatic send(logic [31:0] v, int n);
      for (int i = n - 1; i >= 0; i--) pulse(v[i]);
   endtask

   task automatic sel();
      sk = 1'b0;
      cs = 1'b1;
      tick(4);
   endtask

   task automatic desel();
      sk = 1'b0;
      tick(2);
      cs = 1'b0;
      tick(4);
   endtask

   task automatic cmd(logic [1:0] op, int a, int alen);
      pulse(1'b1);
      send(32'(op), 2);
      send(32'(a), alen);
   endtask

   task automatic prog_wait(string tag);
      desel();
      sel();
      chk(1'b1, 1'b0, tag);
      tick(PROG + 20);
      chk(1'b1, 1'b1, tag);
      desel();
      chk(1'b0, 1'b0, "R2");
   endtask

   task automatic no_prog(string tag);
      desel();
      sel();
      chk(1'b0, 1'b0, tag);
      desel();
   endtask

   task automatic ext16(logic [7:0] a);
      sel();
      cmd(2'b00, 32'(a), 8);
      desel();
   endtask

   task automatic read_chk(int a, int alen, int w, logic [15:0] words[$], string tag);
      sel();
      cmd(2'b10, a, alen);
      chk(1'b1, 1'b0, tag);
      foreach (words[k]) begin
         for (int i = w - 1; i >= 0; i--) begin
            pulse(1'b0);
            chk(1'b1, words[k][i], tag);
         end
      end
      desel();
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(2);
      // R1: output released after reset, contents all ones
      chk(1'b0, 1'b0, "R1");
      sel();
      chk(1'b0, 1'b0, "R2");
      desel();
      read_chk(5, 8, 16, '{16'hFFFF}, "R1");

      // R6: write while locked after reset does nothing
      sel(); cmd(2'b01, 5, 8); send(32'hA5C3, 16);
      no_prog("R6");
      read_chk(5, 8, 16, '{16'hFFFF}, "R6");

      // unlock, then program words (R5, R10)
      ext16(8'hC0);
      sel(); cmd(2'b01, 5, 8); send(32'h1234, 16); prog_wait("R10");
      sel(); cmd(2'b01, 6, 8); send(32'hBEEF, 16); prog_wait("R5");
      sel(); cmd(2'b01, 127, 8); send(32'h0F0F, 16); prog_wait("R5");

      // R3 and R4: streaming and wrap
      read_chk(5, 8, 16, '{16'h1234, 16'hBEEF}, "R4");
      read_chk(127, 8, 16, '{16'h0F0F, 16'hFFFF}, "R4");

      // R7: single erase
      sel(); cmd(2'b11, 6, 8); prog_wait("R7");
      read_chk(6, 8, 16, '{16'hFFFF}, "R7");

      // R12: a full command sent while busy is ignored
      sel(); cmd(2'b01, 10, 8); send(32'h5555, 16);
      desel();
      sel();
      chk(1'b1, 1'b0, "R10");
      cmd(2'b01, 11, 8); send(32'h6666, 16);
      desel();
      tick(PROG);
      read_chk(11, 8, 16, '{16'hFFFF}, "R12");
      read_chk(10, 8, 16, '{16'h5555}, "R12");

      // R13: truncated write
      sel(); cmd(2'b01, 12, 8); send(32'h00, 8);
      no_prog("R13");
      read_chk(12, 8, 16, '{16'hFFFF}, "R13");

      // R6: lock command blocks erase
      ext16(8'h00);
      sel(); cmd(2'b11, 5, 8);
      no_prog("R6");
      read_chk(5, 8, 16, '{16'h1234}, "R6");

      // R9 and R8: fill and clear-all
      ext16(8'hC0);
      sel(); cmd(2'b00, 8'h40, 8); send(32'hA5A5, 16); prog_wait("R9");
      read_chk(0, 8, 16, '{16'hA5A5}, "R9");
      read_chk(77, 8, 16, '{16'hA5A5}, "R9");
      sel(); cmd(2'b00, 8'h80, 8); prog_wait("R8");
      read_chk(3, 8, 16, '{16'hFFFF}, "R8");
      read_chk(77, 8, 16, '{16'hFFFF}, "R8");

      // R11: byte organization, address MSB ignored
      org = 1'b0;
      tick(2);
      sel(); cmd(2'b01, 9'h104, 9); send(32'h3C, 8); prog_wait("R11");
      read_chk(9'h004, 9, 8, '{16'h003C, 16'h00FF}, "R11");
      org = 1'b1;
      tick(2);
      read_chk(2, 8, 16, '{16'h3CFF}, "R11");

      tick(10);
      drain();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got no end of test expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule